// File: doc/BRIEF.md
# Banked DAC Code Selector

This block keeps the 10-bit codes for fifteen output DACs: fourteen gamma taps and one common-voltage channel. Every channel owns four stored banks, numbered 0 to 3 and written through a dedicated bank-load port. Every channel also owns a live latch that software writes one byte at a time through a byte-wide register port, as a serial slave would present it. A two-bit source mode decides what reaches the DACs. It can be a bank picked by two external select pins, a bank picked by a software register, or the live latches directly. The chosen codes are registered, so all fifteen outputs change together on one clock edge.

Latch writes go through a two-state machine with states IDLE and LOW_HELD. In IDLE, a low-byte write captures the byte and the channel number (transition CAPTURE) and moves to LOW_HELD. A high-byte write in IDLE is dropped. In LOW_HELD, a further low-byte write replaces the held byte and channel (RESTAGE) and stays in LOW_HELD. A high-byte write to the held channel writes all ten bits into that latch and returns to IDLE (COMMIT). A high-byte write to any other channel drops the held byte and returns to IDLE (ABANDON). Writes to other registers leave the machine where it is.

Top module: `gdac_bank_ctrl`

## Requirements
- R1: After reset, all fifteen DAC codes, every bank entry, every latch, the mode, soft-select and standby registers all read zero.
- R2: Channel n's latch sits at byte address 2n (code bits 7:0) and 2n+1 (code bits 9:8 in data bits 1:0, bits 7:2 read 0). The common-voltage channel is n=0 and the gamma taps are n=1..14.
- R3: A latch changes only on a high-byte write to the same channel that directly follows a low-byte write to that channel, with no other latch-address write in between. A lone high byte, or a high byte to another channel, is dropped and also discards the held low byte.
- R4: With mode 00, the bank index is the pin pair {sel_pins[1], sel_pins[0]}. It passes two synchronizer flops and the output register, so outputs change on the third rising edge after the pins change.
- R5: With mode 01, the bank index is bits 1:0 of register 40h. Its bits 7:2 read 0. Outputs follow on the edge after the write.
- R6: With mode 10 or 11, each DAC output equals its channel latch one edge after the latch or the mode changes.
- R7: Register 48h holds the mode in bits 1:0, and bits 7:2 read 0. Register 41h is a full 8-bit read/write standby byte.
- R8: Register 4Ah is read-only. Bit 2 is the synchronized load pin, bits 1:0 are the synchronized select pins, and bits 7:3 are 0. The same byte appears on the status port two edges after a pin change.
- R9: Addresses 1Eh–3Fh, 42h–47h, 49h and 4Bh–7Fh read 00h, and writes to them change nothing.
- R10: A bank-load strobe writes bw_code into bank bw_bank, channel bw_chan. A channel index of 15 or more is ignored.
- R11: When the selected bank changes, all fifteen outputs take the new bank's codes on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 7 | Register read address |
| rd_data | output | 8 | Combinational read data |
| sel_pins | input | 2 | External bank select pins |
| load_pin | input | 1 | External load pin, reported in status |
| bw_en | input | 1 | Bank-load strobe |
| bw_bank | input | 2 | Bank index for bank load |
| bw_chan | input | 4 | Channel index for bank load |
| bw_code | input | 10 | Code for bank load |
| dac_codes | output | 150 | Fifteen codes, channel n at bits 10n+9:10n |
| status | output | 8 | Synchronized pin levels, same layout as 4Ah |

## Verification
Register writes take effect on the edge that samples them, and read data is combinational. The bench therefore reads back at the falling edge right after each write. Mode, soft-select, bank-load and latch-commit effects reach dac_codes one edge later, so those checks wait one more falling edge. After a pin change, the bench checks at the second falling edge that the status byte has moved and the outputs have not. It then checks at the third falling edge that all fifteen outputs show the new bank.

// File: rtl/gdac_pkg.sv
package gdac_pkg;

    typedef enum logic [1:0] {
        SRC_PINS   = 2'b00,
        SRC_SOFT   = 2'b01,
        SRC_LATCH  = 2'b10,
        SRC_LATCH2 = 2'b11
    } src_mode_e;

    typedef enum logic {
        ST_IDLE     = 1'b0,
        ST_LOW_HELD = 1'b1
    } lat_state_e;

    localparam int ADDR_SOFT = 'h40;
    localparam int ADDR_STBY = 'h41;
    localparam int ADDR_CTRL = 'h48;
    localparam int ADDR_STAT = 'h4A;

endpackage

// File: rtl/gdac_pin_sync.sv
module gdac_pin_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;
    logic [1:0]   age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end

    // cycles since reset, used only to bound the assertion window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            age_q <= '0;
        else if (age_q != 2'd2)
            age_q <= age_q + 2'd1;
    end

    // R8 / R4: pin levels appear after exactly two flops
    p_sync_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (q == $past(d, 2)));

endmodule

// File: rtl/gdac_latch_fsm.sv
module gdac_latch_fsm
    import gdac_pkg::*;
#(
    parameter int NCH = 15,
    parameter int CW  = 10,
    parameter int AW  = 7,
    parameter int DW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic              rd_hit,
    output logic [DW-1:0]     rd_byte,
    output logic [NCH*CW-1:0] latch_flat
);

    localparam int CHW  = $clog2(NCH);
    localparam int HIW  = CW - DW;
    localparam int LTOP = 2 * NCH;

    lat_state_e     state_q, state_n;
    logic [CHW-1:0] held_ch_q, held_ch_n;
    logic [DW-1:0]  held_lo_q, held_lo_n;
    logic           commit;

    logic           wr_lat;
    logic           wr_hi;
    logic [CHW-1:0] wr_ch;

    logic [CW-1:0]  latch_q [NCH];

    assign wr_lat = wr_en && (int'(wr_addr) < LTOP);
    assign wr_hi  = wr_addr[0];
    assign wr_ch  = CHW'(wr_addr[AW-1:1]);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            held_ch_q <= '0;
            held_lo_q <= '0;
        end else begin
            state_q   <= state_n;
            held_ch_q <= held_ch_n;
            held_lo_q <= held_lo_n;
        end
    end

    // next state and commit strobe
    always_comb begin
        state_n   = state_q;
        held_ch_n = held_ch_q;
        held_lo_n = held_lo_q;
        commit    = 1'b0;
        if (wr_lat) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (!wr_hi) begin            // CAPTURE
                        state_n   = ST_LOW_HELD;
                        held_ch_n = wr_ch;
                        held_lo_n = wr_data;
                    end
                end
                ST_LOW_HELD: begin
                    if (!wr_hi) begin            // RESTAGE
                        held_ch_n = wr_ch;
                        held_lo_n = wr_data;
                    end else if (wr_ch == held_ch_q) begin
                        commit  = 1'b1;          // COMMIT
                        state_n = ST_IDLE;
                    end else begin
                        state_n = ST_IDLE;       // ABANDON
                    end
                end
            endcase
        end
    end

    // latch storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++)
                latch_q[i] <= '0;
        end else if (commit) begin
            for (int i = 0; i < NCH; i++)
                if (held_ch_q == CHW'(i))
                    latch_q[i] <= {wr_data[HIW-1:0], held_lo_q};
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_flat
        assign latch_flat[g*CW +: CW] = latch_q[g];
    end

    // read side
    logic [CHW-1:0] rd_ch;
    logic [CW-1:0]  rd_code;

    assign rd_hit = int'(rd_addr) < LTOP;
    assign rd_ch  = CHW'(rd_addr[AW-1:1]);

    always_comb begin
        rd_code = '0;
        for (int i = 0; i < NCH; i++)
            if (rd_ch == CHW'(i))
                rd_code = latch_q[i];
        if (rd_addr[0])
            rd_byte = DW'(rd_code[CW-1:DW]);
        else
            rd_byte = rd_code[DW-1:0];
    end

    // R3: a latch moves only on a high-byte write out of LOW_HELD
    p_commit_after_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_flat != $past(latch_flat)) |->
            ($past(state_q) == ST_LOW_HELD && $past(wr_lat) && $past(wr_hi)));

endmodule

// File: rtl/gdac_bank_store.sv
module gdac_bank_store
    import gdac_pkg::*;
#(
    parameter int NCH   = 15,
    parameter int CW    = 10,
    parameter int NBANK = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bw_en,
    input  logic [$clog2(NBANK)-1:0] bw_bank,
    input  logic [$clog2(NCH)-1:0]   bw_chan,
    input  logic [CW-1:0]            bw_code,
    input  src_mode_e                mode,
    input  logic [$clog2(NBANK)-1:0] pin_bank,
    input  logic [$clog2(NBANK)-1:0] soft_bank,
    input  logic [NCH*CW-1:0]        latch_flat,
    output logic [NCH*CW-1:0]        dac_flat
);

    localparam int BW  = $clog2(NBANK);
    localparam int CHW = $clog2(NCH);

    logic [CW-1:0] bank_q [NBANK][NCH];
    logic [CW-1:0] nxt    [NCH];
    logic [BW-1:0] act_bank;
    logic          use_latch;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < NBANK; b++)
                for (int c = 0; c < NCH; c++)
                    bank_q[b][c] <= '0;
        end else if (bw_en) begin
            for (int b = 0; b < NBANK; b++)
                for (int c = 0; c < NCH; c++)
                    if (bw_bank == BW'(b) && bw_chan == CHW'(c))
                        bank_q[b][c] <= bw_code;
        end
    end

    always_comb begin
        act_bank  = '0;
        use_latch = 1'b0;
        unique case (mode)
            SRC_PINS:   act_bank  = pin_bank;
            SRC_SOFT:   act_bank  = soft_bank;
            SRC_LATCH:  use_latch = 1'b1;
            SRC_LATCH2: use_latch = 1'b1;
        endcase
    end

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            nxt[c] = '0;
            for (int b = 0; b < NBANK; b++)
                if (act_bank == BW'(b))
                    nxt[c] = bank_q[b][c];
            if (use_latch)
                nxt[c] = latch_flat[c*CW +: CW];
        end
    end

    // one output register for all channels
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dac_flat <= '0;
        else
            for (int c = 0; c < NCH; c++)
                dac_flat[c*CW +: CW] <= nxt[c];
    end

    // R6: in a latch mode the outputs track the latches one edge later
    p_latch_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode[1]) |-> (dac_flat == $past(latch_flat)));

endmodule

// File: rtl/gdac_bank_ctrl.sv
module gdac_bank_ctrl
    import gdac_pkg::*;
#(
    parameter int NCH   = 15,
    parameter int CW    = 10,
    parameter int NBANK = 4,
    parameter int AW    = 7,
    parameter int DW    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [DW-1:0]            wr_data,
    input  logic [AW-1:0]            rd_addr,
    output logic [DW-1:0]            rd_data,
    input  logic [$clog2(NBANK)-1:0] sel_pins,
    input  logic                     load_pin,
    input  logic                     bw_en,
    input  logic [$clog2(NBANK)-1:0] bw_bank,
    input  logic [$clog2(NCH)-1:0]   bw_chan,
    input  logic [CW-1:0]            bw_code,
    output logic [NCH*CW-1:0]        dac_codes,
    output logic [DW-1:0]            status
);

    localparam int BW   = $clog2(NBANK);
    localparam int SW   = BW + 1;
    localparam int LTOP = 2 * NCH;

    logic [SW-1:0]     pins_s;
    logic [BW-1:0]     soft_q;
    logic [DW-1:0]     stby_q;
    src_mode_e         mode_q;
    logic              lat_hit;
    logic [DW-1:0]     lat_byte;
    logic [NCH*CW-1:0] latch_flat;

    gdac_pin_sync #(.W(SW)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({load_pin, sel_pins}),
        .q     (pins_s)
    );

    gdac_latch_fsm #(.NCH(NCH), .CW(CW), .AW(AW), .DW(DW)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_hit     (lat_hit),
        .rd_byte    (lat_byte),
        .latch_flat (latch_flat)
    );

    gdac_bank_store #(.NCH(NCH), .CW(CW), .NBANK(NBANK)) u_banks (
        .clk        (clk),
        .rst_n      (rst_n),
        .bw_en      (bw_en),
        .bw_bank    (bw_bank),
        .bw_chan    (bw_chan),
        .bw_code    (bw_code),
        .mode       (mode_q),
        .pin_bank   (pins_s[BW-1:0]),
        .soft_bank  (soft_q),
        .latch_flat (latch_flat),
        .dac_flat   (dac_codes)
    );

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            soft_q <= '0;
            stby_q <= '0;
            mode_q <= SRC_PINS;
        end else if (wr_en) begin
            if (int'(wr_addr) == ADDR_SOFT)
                soft_q <= wr_data[BW-1:0];
            if (int'(wr_addr) == ADDR_STBY)
                stby_q <= wr_data;
            if (int'(wr_addr) == ADDR_CTRL)
                mode_q <= src_mode_e'(wr_data[1:0]);
        end
    end

    assign status = DW'(pins_s);

    always_comb begin
        rd_data = '0;
        if (lat_hit)
            rd_data = lat_byte;
        else if (int'(rd_addr) == ADDR_SOFT)
            rd_data = DW'(soft_q);
        else if (int'(rd_addr) == ADDR_STBY)
            rd_data = stby_q;
        else if (int'(rd_addr) == ADDR_CTRL)
            rd_data = DW'(mode_q);
        else if (int'(rd_addr) == ADDR_STAT)
            rd_data = DW'(pins_s);
    end

    logic rd_reserved;
    assign rd_reserved = (int'(rd_addr) >= LTOP) &&
                         (int'(rd_addr) != ADDR_SOFT) && (int'(rd_addr) != ADDR_STBY) &&
                         (int'(rd_addr) != ADDR_CTRL) && (int'(rd_addr) != ADDR_STAT);

    // R9: reserved addresses read as zero
    p_reserved_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_reserved |-> (rd_data == '0));

    // R7: mode register follows a control write on the next edge
    p_ctrl_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_addr) == ADDR_CTRL) |=> (mode_q == src_mode_e'($past(wr_data[1:0]))));

endmodule

// File: tb/gdac_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module gdac_bank_ctrl_tb_top;

    localparam int NCH = 15;
    localparam int CW  = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [6:0]    wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [6:0]    rd_addr = '0;
    logic [7:0]    rd_data;
    logic [1:0]    sel_pins = '0;
    logic          load_pin = 1'b0;
    logic          bw_en = 1'b0;
    logic [1:0]    bw_bank = '0;
    logic [3:0]    bw_chan = '0;
    logic [9:0]    bw_code = '0;
    logic [149:0]  dac_codes;
    logic [7:0]    status;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    int bank_m [4][NCH];
    int latch_m [NCH];
    int soft_m = 0, stby_m = 0, mode_m = 0;

    always #2 clk = ~clk;

    gdac_bank_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .sel_pins(sel_pins), .load_pin(load_pin),
        .bw_en(bw_en), .bw_bank(bw_bank), .bw_chan(bw_chan), .bw_code(bw_code),
        .dac_codes(dac_codes), .status(status)
    );

    task automatic chk(input string rq, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    function automatic int pat(input int b, input int c);
        return (b * 263 + c * 37 + 5) % 1024;
    endfunction

    function automatic int dac(input int c);
        return int'(dac_codes[c*CW +: CW]);
    endfunction

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 7'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        rd_addr = 7'(a);
        #0.5;
        v = int'(rd_data);
    endtask

    function automatic int exp_rd(input int a);
        if (a < 2 * NCH)
            return (a % 2 == 0) ? (latch_m[a/2] & 255) : (latch_m[a/2] >> 8);
        if (a == 'h40) return soft_m;
        if (a == 'h41) return stby_m;
        if (a == 'h48) return mode_m;
        if (a == 'h4A) return {29'd0, load_pin, sel_pins};
        return 0;
    endfunction

    task automatic chk_all_dac(input string rq, input int src);
        // src 0..3 = bank, 4 = latch
        for (int c = 0; c < NCH; c++)
            chk(rq, dac(c), (src == 4) ? latch_m[c] : bank_m[src][c]);
    endtask

    task automatic sweep_regs(input string rq);
        int v;
        for (int a = 0; a < 128; a++) begin
            rd(a, v);
            chk(rq, v, exp_rd(a));
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int v, prev;
        for (int b = 0; b < 4; b++)
            for (int c = 0; c < NCH; c++)
                bank_m[b][c] = 0;
        for (int c = 0; c < NCH; c++) latch_m[c] = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk_all_dac("R1", 0);
        sweep_regs("R1");

        // R10: load banks, including one out-of-range channel write
        for (int b = 0; b < 4; b++)
            for (int c = 0; c < NCH; c++) begin
                @(negedge clk);
                bw_en = 1'b1; bw_bank = 2'(b); bw_chan = 4'(c); bw_code = 10'(pat(b, c));
                bank_m[b][c] = pat(b, c);
            end
        @(negedge clk);
        bw_bank = 2'd0; bw_chan = 4'd15; bw_code = 10'h3FF;
        @(negedge clk);
        bw_en = 1'b0;
        @(negedge clk);
        chk_all_dac("R10", 0);

        // R4, R11, R8: pin-selected banks with latency
        prev = 0;
        for (int k = 0; k < 4; k++) begin
            int b = 3 - k;
            @(negedge clk);
            sel_pins = 2'(b); load_pin = k[0];
            @(negedge clk);
            @(negedge clk);
            chk("R8", int'(status), {29'd0, load_pin, sel_pins});
            chk_all_dac("R4", prev);
            @(negedge clk);
            chk_all_dac("R11", b);
            prev = b;
        end
        // R8: status register ignores writes
        wr('h4A, 'hFF);
        rd('h4A, v);
        chk("R8", v, {29'd0, load_pin, sel_pins});

        // R7: control keeps only bits 1:0; enter soft mode
        wr('h48, 'hFD); mode_m = 1;
        rd('h48, v);
        chk("R7", v, 1);
        sel_pins = 2'd0;
        for (int b = 0; b < 4; b++) begin
            int sb = (b + 2) % 4;
            wr('h40, 'hFC | sb); soft_m = sb;
            rd('h40, v);
            chk("R5", v, sb);
            @(negedge clk);
            chk_all_dac("R5", sb);
        end
        wr('h41, 'hA5); stby_m = 'hA5;
        rd('h41, v); chk("R7", v, 'hA5);
        wr('h41, 'h5A); stby_m = 'h5A;
        rd('h41, v); chk("R7", v, 'h5A);

        // R2, R3: fill latches, low byte alone does not commit
        for (int c = 0; c < NCH; c++) begin
            int code = (c * 71 + 300) % 1024;
            wr(2*c, code & 255);
            rd(2*c, v);
            chk("R3", v, latch_m[c] & 255);
            wr(2*c + 1, 'hA8 | (code >> 8));
            latch_m[c] = code;
            rd(2*c, v);     chk("R2", v, code & 255);
            rd(2*c + 1, v); chk("R2", v, code >> 8);
        end

        // R6: both latch mode encodings
        wr('h48, 2); mode_m = 2;
        @(negedge clk);
        chk_all_dac("R6", 4);
        wr('h48, 3); mode_m = 3;
        @(negedge clk);
        chk_all_dac("R6", 4);

        // R3: lone high, abandoned low, then a proper pair
        wr(11, 3);
        @(negedge clk);
        chk("R3", dac(5), latch_m[5]);
        wr(12, 'h11);
        @(negedge clk);
        chk("R3", dac(6), latch_m[6]);
        wr(15, 2);
        wr(13, 1);
        @(negedge clk);
        chk("R3", dac(6), latch_m[6]);
        chk("R3", dac(7), latch_m[7]);
        wr(12, 'h22);
        wr(13, 2);
        latch_m[6] = 'h222;
        @(negedge clk);
        chk("R3", dac(6), 'h222);
        chk_all_dac("R6", 4);

        // R9: writes to reserved addresses change nothing
        for (int a = 30; a < 128; a++)
            if (a != 'h40 && a != 'h41 && a != 'h48 && a != 'h4A)
                wr(a, 'hFF);
        @(negedge clk);
        sweep_regs("R9");
        chk_all_dac("R9", 4);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule